// File: doc/BRIEF.md
# Real-Time Counter with Prescaler

This block is a 16-bit real-time counter that runs from its own slow clock, asynchronous to the bus clock. The slow clock is divided by a selectable prescaler, and each divided tick moves the count up by one. When the count equals the period value on a tick, the count returns to zero and an overflow is signalled. When it equals the compare value on a tick, a compare match is signalled. Each of the two conditions sets a sticky interrupt flag on the bus side and produces a one-cycle event pulse on the counter side.

Software uses a small register port on the bus clock. Writes to the control, period, compare and count registers are held on the bus side and handed to the counter domain with a toggle handshake. A busy bit stays high until the counter domain has taken the write, and further writes to those registers are dropped while it is high. Flags are raised in the counter domain, carried back over a synchronizer, gated by per-flag enables into one interrupt line, and cleared by writing one. Event pulses are thinned when the period is very small, so that a slow consumer can keep up; interrupt flags are never thinned.

Register map (addr_i): 0 control (bits 2:0 prescaler select), 1 period, 2 compare, 3 count (write only, reads 0), 4 status (bit 0 overflow flag, bit 1 compare flag, bit 2 busy; write 1 to bit 0 or 1 to clear that flag), 5 interrupt enable (bit 0 overflow, bit 1 compare).

Top module: `rtc_timer`

## Requirements
- R1: After reset the prescaler select is 000 (stopped), the count is 0, both flags are 0, busy is 0 and irq_o is low.
- R2: Prescaler select codes divide the counter clock as 000 stopped, 001 by 1, 010 by 2, 011 by 8, 100 by 16, 101 by 64, 110 by 256, 111 by 1024; with period P and divider D (P of 2 or more), overflow events are spaced D*(P+1) counter-clock cycles apart.
- R3: On a tick where the count equals the period, the count goes to 0 on that tick and the overflow flag (status bit 0) is set.
- R4: On a tick where the count equals the compare value, the compare flag (status bit 1) is set and a compare event pulse follows; it leads the overflow event by (P-C)*D counter-clock cycles.
- R5: Event pulses occur on every third match when the period is 0, every second match when it is 1, and every match when it is 2 or more.
- R6: irq_o is high when a flag is set and its enable bit (address 5, bit 0 overflow, bit 1 compare) is set, and low when no set flag is enabled; flags are set on every match, independent of event thinning.
- R7: Writing 1 to status bit 0 or bit 1 clears only that flag; a written 0 leaves the flag unchanged.
- R8: Control reads return the 3-bit select in bits 2:0 and zero in bits 15:3, whatever was written there.
- R9: A write to addresses 0 to 3 sets busy (status bit 2) from the next bus cycle until the counter domain has taken it; a write to addresses 0 to 3 while busy is ignored.
- R10: A write to the count register loads the counter with the written value.
- R11: While the select is 000 the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rtc_clk_i | input | 1 | Counter clock, asynchronous to clk_i |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_en_i | input | 1 | Register write strobe (bus clock) |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request (bus clock) |
| evt_ovf_o | output | 1 | Overflow event pulse (counter clock) |
| evt_cmp_o | output | 1 | Compare event pulse (counter clock) |
| cnt_o | output | 16 | Current count (counter clock) |

## Verification
The counter is run with several divider codes (by 1, by 8, by 1024) and periods, and the spacing between successive event pulses is measured in counter-clock cycles; this separates a wrong divider code, an off-by-one at the wrap and a missed reload. Periods 0, 1 and 2 tell the three thinning ratios apart, and the lead of the compare pulse over the overflow pulse separates compare from period matching. Back-to-back writes while busy, writes of ones to reserved control bits, single-bit flag clears and enable toggling check the register port.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned PRE_W = 10;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_PER  = 3'd1,
    A_CMP  = 3'd2,
    A_CNT  = 3'd3,
    A_STAT = 3'd4,
    A_IEN  = 3'd5
  } rtc_addr_e;

  // terminal value of the prescaler counter (divider - 1)
  function automatic logic [PRE_W-1:0] pre_lim(input logic [2:0] sel);
    case (sel)
      3'd2:    pre_lim = PRE_W'(1);
      3'd3:    pre_lim = PRE_W'(7);
      3'd4:    pre_lim = PRE_W'(15);
      3'd5:    pre_lim = PRE_W'(63);
      3'd6:    pre_lim = PRE_W'(255);
      3'd7:    pre_lim = PRE_W'(1023);
      default: pre_lim = '0;
    endcase
  endfunction
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [2:0]       sel_q;
  logic             restart;

  assign restart = (sel_i != sel_q) || (sel_i == 3'd0);
  assign tick_o  = !restart && (cnt_q == pre_lim(sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel_i;
      if (restart || tick_o) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_evt_thin.sv
module rtc_evt_thin #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          hit_i,
  input  logic [CW-1:0] per_i,
  output logic          evt_o
);
  logic [1:0] dec_q;
  logic       fire;

  always_comb begin
    if (per_i == CW'(0))      fire = (dec_q == 2'd2);
    else if (per_i == CW'(1)) fire = (dec_q == 2'd1);
    else                      fire = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= '0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= hit_i && fire;
      if (clr_i)                dec_q <= '0;
      else if (hit_i && fire)   dec_q <= '0;
      else if (hit_i)           dec_q <= dec_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_timer.sv
module rtc_timer
  import rtc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rtc_clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  output logic          irq_o,
  output logic          evt_ovf_o,
  output logic          evt_cmp_o,
  output logic [CW-1:0] cnt_o
);
  localparam int unsigned NF = 2;  // bit 0 overflow, bit 1 compare

  // ---------------- bus domain ----------------
  rtc_addr_e     wa;
  logic [2:0]    ctrl_q;
  logic [CW-1:0] per_q, cmp_q, hold_data_q;
  rtc_addr_e     hold_addr_q;
  logic [NF-1:0] ien_q, flags_q, flag_set;
  logic          req_tog_q, ack_s, busy, acc;
  logic [NF-1:0] hit_tog, hit_s, hit_s_q;

  assign wa   = rtc_addr_e'(addr_i);
  assign busy = req_tog_q ^ ack_s;
  assign acc  = wr_en_i && !busy &&
                (wa == A_CTRL || wa == A_PER || wa == A_CMP || wa == A_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      per_q       <= '0;
      cmp_q       <= '0;
      hold_data_q <= '0;
      hold_addr_q <= A_CTRL;
      req_tog_q   <= 1'b0;
      ien_q       <= '0;
    end else begin
      if (acc) begin
        hold_data_q <= wdata_i;
        hold_addr_q <= wa;
        req_tog_q   <= ~req_tog_q;
        case (wa)
          A_CTRL:  ctrl_q <= wdata_i[2:0];
          A_PER:   per_q  <= wdata_i;
          A_CMP:   cmp_q  <= wdata_i;
          default: ;
        endcase
      end
      if (wr_en_i && wa == A_IEN) ien_q <= wdata_i[NF-1:0];
    end
  end

  rtc_sync #(.W(NF)) u_hit_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(hit_tog), .q_o(hit_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_s_q <= '0;
    else         hit_s_q <= hit_s;
  end
  assign flag_set = hit_s ^ hit_s_q;

  generate
    for (genvar f = 0; f < NF; f++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                       flags_q[f] <= 1'b0;
        else if (flag_set[f])                              flags_q[f] <= 1'b1;
        else if (wr_en_i && wa == A_STAT && wdata_i[f])    flags_q[f] <= 1'b0;
      end
    end
  endgenerate

  assign irq_o = |(flags_q & ien_q);

  always_comb begin
    rdata_o = '0;
    case (wa)
      A_CTRL: rdata_o[2:0]  = ctrl_q;
      A_PER:  rdata_o       = per_q;
      A_CMP:  rdata_o       = cmp_q;
      A_STAT: rdata_o[NF:0] = {busy, flags_q};
      A_IEN:  rdata_o[NF-1:0] = ien_q;
      default: ;
    endcase
  end

  // ---------------- counter domain ----------------
  logic          req_s, ack_tog_q, apply, cnt_wr, per_wr;
  logic [2:0]    sel_r;
  logic [CW-1:0] per_r, cmp_r, cnt_r;
  logic          tick, ovf_hit, cmp_hit;

  rtc_sync #(.W(1)) u_req_sync (
    .clk_i(rtc_clk_i), .rst_ni(rst_ni), .d_i(req_tog_q), .q_o(req_s)
  );
  rtc_sync #(.W(1)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_tog_q), .q_o(ack_s)
  );

  // hold registers are stable while the request is in flight
  assign apply  = req_s ^ ack_tog_q;
  assign cnt_wr = apply && hold_addr_q == A_CNT;
  assign per_wr = apply && hold_addr_q == A_PER;

  always_ff @(posedge rtc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_tog_q <= 1'b0;
      sel_r     <= '0;
      per_r     <= '0;
      cmp_r     <= '0;
    end else begin
      ack_tog_q <= req_s;
      if (apply) begin
        case (hold_addr_q)
          A_CTRL:  sel_r <= hold_data_q[2:0];
          A_PER:   per_r <= hold_data_q;
          A_CMP:   cmp_r <= hold_data_q;
          default: ;
        endcase
      end
    end
  end

  rtc_prescaler u_pre (
    .clk_i(rtc_clk_i), .rst_ni(rst_ni), .sel_i(sel_r), .tick_o(tick)
  );

  assign ovf_hit = tick && (cnt_r == per_r);
  assign cmp_hit = tick && (cnt_r == cmp_r);

  always_ff @(posedge rtc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_r   <= '0;
      hit_tog <= '0;
    end else begin
      if (cnt_wr)       cnt_r <= hold_data_q;
      else if (ovf_hit) cnt_r <= '0;
      else if (tick)    cnt_r <= cnt_r + 1'b1;
      if (ovf_hit) hit_tog[0] <= ~hit_tog[0];
      if (cmp_hit) hit_tog[1] <= ~hit_tog[1];
    end
  end

  assign cnt_o = cnt_r;

  rtc_evt_thin #(.CW(CW)) u_thin_ovf (
    .clk_i(rtc_clk_i), .rst_ni(rst_ni), .clr_i(per_wr),
    .hit_i(ovf_hit), .per_i(per_r), .evt_o(evt_ovf_o)
  );
  rtc_evt_thin #(.CW(CW)) u_thin_cmp (
    .clk_i(rtc_clk_i), .rst_ni(rst_ni), .clr_i(per_wr),
    .hit_i(cmp_hit), .per_i(per_r), .evt_o(evt_cmp_o)
  );
endmodule

// File: rtl/rtc_timer_chk.sv
module rtc_timer_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rtc_clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [2:0]    addr_i,
  input logic [CW-1:0] wdata_i,
  input logic [CW-1:0] rdata_o,
  input logic          irq_o,
  input logic          evt_ovf_o,
  input logic          evt_cmp_o,
  input logic          acc,
  input logic          busy,
  input logic [CW-1:0] per_q,
  input logic [1:0]    flags_q,
  input logic [1:0]    ien_q,
  input logic          ovf_hit,
  input logic          cmp_hit,
  input logic          cnt_wr,
  input logic [CW-1:0] cnt_r,
  input logic [2:0]    sel_r
);
  p_busy_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> busy);
  p_busy_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy && addr_i == 3'd1) |=> $stable(per_q));
  p_ctrl_rsv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd0) |-> (rdata_o[CW-1:3] == '0));
  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[0] && !(wr_en_i && addr_i == 3'd4 && wdata_i[0])) |=> flags_q[0]);
  p_irq_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == 2'b00) |-> !irq_o);
  p_wrap_r3: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    (ovf_hit && !cnt_wr) |=> (cnt_r == '0));
  p_hold_r11: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    (sel_r == 3'd0 && !cnt_wr) |=> $stable(cnt_r));
  p_evt_ovf_r5: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    evt_ovf_o |-> $past(ovf_hit));
  p_evt_cmp_r4: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    evt_cmp_o |-> $past(cmp_hit));
endmodule

bind rtc_timer rtc_timer_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rtc_clk_i(rtc_clk_i), .rst_ni(rst_ni),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .irq_o(irq_o), .evt_ovf_o(evt_ovf_o), .evt_cmp_o(evt_cmp_o),
  .acc(acc), .busy(busy), .per_q(per_q), .flags_q(flags_q), .ien_q(ien_q),
  .ovf_hit(ovf_hit), .cmp_hit(cmp_hit), .cnt_wr(cnt_wr), .cnt_r(cnt_r),
  .sel_r(sel_r)
);

// File: tb/rtc_timer_tb.sv
module rtc_timer_tb;
  logic        clk_i = 0, rtc_clk_i = 0, rst_ni = 0;
  logic        wr_en_i = 0;
  logic [2:0]  addr_i = 0;
  logic [15:0] wdata_i = 0;
  logic [15:0] rdata_o, cnt_o;
  logic        irq_o, evt_ovf_o, evt_cmp_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #5  clk_i = ~clk_i;
  always #15 rtc_clk_i = ~rtc_clk_i;

  rtc_timer u_dut (.*);

  // event monitor in counter-clock cycles
  int rcyc = 0, ovf_n = 0, cmp_n = 0;
  int ovf_last = 0, ovf_prev = 0, cmp_last = 0, cmp_prev = 0;
  always @(negedge rtc_clk_i) begin
    rcyc <= rcyc + 1;
    if (evt_ovf_o) begin ovf_prev <= ovf_last; ovf_last <= rcyc; ovf_n <= ovf_n + 1; end
    if (evt_cmp_o) begin cmp_prev <= cmp_last; cmp_last <= rcyc; cmp_n <= cmp_n + 1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk_i); #1;
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic wait_idle;
    logic [15:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(3'd4, s);
      if (!s[2]) return;
      @(posedge clk_i); #1;
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [15:0] per, input logic [15:0] cmpv);
    wr(3'd0, 16'd0); wait_idle;
    wr(3'd1, per);   wait_idle;
    wr(3'd2, cmpv);  wait_idle;
    wr(3'd3, 16'd0); wait_idle;
    wr(3'd0, {13'd0, sel}); wait_idle;
  endtask

  task automatic meas_ovf(output int iv);
    int n0 = ovf_n;
    for (int i = 0; i < 20000 && ovf_n < n0 + 3; i++) @(negedge rtc_clk_i);
    iv = ovf_last - ovf_prev;
  endtask

  task automatic meas_cmp(output int iv);
    int n0 = cmp_n;
    for (int i = 0; i < 20000 && cmp_n < n0 + 3; i++) @(negedge rtc_clk_i);
    iv = cmp_last - cmp_prev;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(3'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(3'd4, v); chk(v == 0, "R1 status", v, 0);
    chk(irq_o == 0, "R1 irq", irq_o, 0);
    repeat (20) @(negedge rtc_clk_i);
    chk(cnt_o == 0, "R1 R11 count stopped", cnt_o, 0);
  endtask

  task automatic t_rsv;
    logic [15:0] v;
    wr(3'd0, 16'hFFF8); wait_idle;
    rd(3'd0, v); chk(v == 0, "R8 reserved zero", v, 0);
  endtask

  task automatic t_busy;
    logic [15:0] v;
    wr(3'd1, 16'h0022);
    rd(3'd4, v); chk(v[2] == 1, "R9 busy set", v[2], 1);
    wr(3'd2, 16'h0055);
    wait_idle;
    rd(3'd4, v); chk(v[2] == 0, "R9 busy clear", v[2], 0);
    rd(3'd2, v); chk(v == 0, "R9 write while busy ignored", v, 0);
    rd(3'd1, v); chk(v == 16'h22, "R9 period taken", v, 16'h22);
  endtask

  task automatic t_load;
    logic [15:0] a;
    wr(3'd3, 16'h1234); wait_idle;
    repeat (3) @(negedge rtc_clk_i);
    a = cnt_o;
    chk(a == 16'h1234, "R10 count load", a, 16'h1234);
    repeat (30) @(negedge rtc_clk_i);
    chk(cnt_o == 16'h1234, "R11 hold while stopped", cnt_o, 16'h1234);
  endtask

  task automatic t_div;
    int iv, ic, d;
    cfg(3'd1, 16'd4, 16'd2);
    meas_ovf(iv); chk(iv == 5, "R2 R3 div1 per4", iv, 5);
    meas_cmp(ic); chk(ic == 5, "R4 compare interval", ic, 5);
    d = (((ovf_last - cmp_last) % 5) + 5) % 5;
    chk(d == 2, "R4 compare lead", d, 2);
    cfg(3'd3, 16'd3, 16'd0);
    meas_ovf(iv); chk(iv == 32, "R2 div8 per3", iv, 32);
    cfg(3'd7, 16'd2, 16'd0);
    meas_ovf(iv); chk(iv == 3072, "R2 div1024 per2", iv, 3072);
  endtask

  task automatic t_thin;
    int iv;
    logic [15:0] v;
    cfg(3'd1, 16'd0, 16'd0);
    meas_ovf(iv); chk(iv == 3, "R5 per0 ovf every third", iv, 3);
    meas_cmp(iv); chk(iv == 3, "R5 per0 cmp every third", iv, 3);
    wr(3'd4, 16'h0003);
    repeat (2) @(negedge rtc_clk_i);
    repeat (4) @(posedge clk_i); #1;
    rd(3'd4, v); chk(v[0] == 1, "R6 flag not thinned", v[0], 1);
    cfg(3'd2, 16'd1, 16'd0);
    meas_ovf(iv); chk(iv == 8, "R5 per1 every second", iv, 8);
    cfg(3'd1, 16'd2, 16'd0);
    meas_ovf(iv); chk(iv == 3, "R5 per2 every match", iv, 3);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    cfg(3'd1, 16'd10, 16'd3);
    repeat (100) @(posedge clk_i); #1;
    rd(3'd4, v); chk(v[1:0] == 2'b11, "R3 R4 flags set", v[1:0], 3);
    chk(irq_o == 0, "R6 irq masked", irq_o, 0);
    wr(3'd5, 16'h0001); #1;
    chk(irq_o == 1, "R6 irq enabled", irq_o, 1);
    wr(3'd5, 16'h0000); #1;
    chk(irq_o == 0, "R6 irq disabled", irq_o, 0);
    wr(3'd0, 16'd0); wait_idle;
    repeat (40) @(posedge clk_i);
    wr(3'd4, 16'h0001);
    rd(3'd4, v); chk(v[1:0] == 2'b10, "R7 clear overflow only", v[1:0], 2);
    wr(3'd4, 16'h0000);
    rd(3'd4, v); chk(v[1:0] == 2'b10, "R7 zero write no effect", v[1:0], 2);
    wr(3'd5, 16'h0002); #1;
    chk(irq_o == 1, "R6 compare irq", irq_o, 1);
    wr(3'd4, 16'h0002);
    rd(3'd4, v); chk(v[1:0] == 2'b00, "R7 clear compare", v[1:0], 0);
    chk(irq_o == 0, "R6 irq after clear", irq_o, 0);
    v = cnt_o;
    repeat (30) @(negedge rtc_clk_i);
    chk(cnt_o == v, "R11 stop holds count", cnt_o, v);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    repeat (2) @(posedge clk_i); #1;
    t_reset;
    t_rsv;
    t_busy;
    t_load;
    t_div;
    t_thin;
    t_irq;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule